// File: doc/BRIEF.md
# Multi-word level interrupt aggregator

This block gathers level-sensitive interrupt sources into 32-bit words, up to four words per instance, and folds them onto a small set of parent interrupt lines. Each word keeps an enable register, a wake-enable register and a read-only status register. The status register is a one-clock registered copy of the raw source inputs. A source is pending when its status bit and its enable bit are both set. Each parent line has its own routing mask for every word, and it rises when any pending source inside that mask is set.

There is no acknowledge action. A status bit follows its source, so a parent line stays high for as long as a selected and enabled source holds its request. A separate wake line reports any raw status bit whose wake-enable bit is set, whether or not the normal enable is set.

A source bit that no parent mask selects is unused. Its enable and wake-enable bits cannot be set, so it can drive neither the parents nor the wake line. After reset the enable registers hold a forward mask given at elaboration, restricted to used bits.

The word count, the parent count, the routing masks and the forward mask are parameters. The routing masks are packed parent-major, then by word. Control flows straight from the register bus and needs no sequencing, so the block holds no state machine.

Top module: `mlirq_aggregator`

## Requirements
- R1: During and after reset, every enable register holds FWD_MASK ANDed with the used-bit mask of its word, every wake-enable register is zero, the parent and wake outputs are low, and `bus_rdata` is zero.
- R2: Word n sits at byte address 0x10*n. Its enable register is at offset 0x0, its status register at 0x4 and its wake-enable register at 0x8. Offset 0xC, and any word index at or above NUM_WORDS, reads as zero.
- R3: A read started with `bus_rd` high at a clock edge returns the addressed register on `bus_rdata` after that edge. While `bus_rd` is low, `bus_rdata` holds its last value.
- R4: Status bit i of word n equals `src_i[32*n+i]` as sampled at the previous clock edge.
- R5: Parent p is high exactly when some word n has a bit that is set in status, set in enable, and set in routing mask `MAP_MASK[(p*NUM_WORDS+n)*32 +: 32]`.
- R6: There is no acknowledge. A parent stays high while its source stays high, and goes low one clock after the source drops.
- R7: Writes to a status offset change no register and no output.
- R8: Bits that no parent mask selects read back as zero in the enable and wake-enable registers, whatever value is written, and they never raise a parent or the wake line.
- R9: `wake_irq` is high exactly when some used status bit has its wake-enable bit set, independent of the enable registers.
- R10: A write to an enable register takes effect at the clock edge that accepts it, and the parents reflect the new value right after that edge. The enable register changes only on such a write.
- R11: Sources in every word, not only word 0, reach the parents through their own per-word masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_WORDS*32 | Raw level source requests, word n at bits [32n+31:32n] |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid after the edge that accepted the read |
| parent_irq | output | NUM_PARENTS | Parent interrupt lines |
| wake_irq | output | 1 | Wake request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never both high, and that sources are plain levels that can change at any clock. The bench changes inputs only on the falling clock edge and performs one bus access at a time. Each source pattern is held for at least one full clock before the outputs are sampled, so the single status register stage is always taken into account.

// File: rtl/mlirq_pkg.sv
package mlirq_pkg;

    localparam int unsigned WORD_BITS    = 32;
    localparam int unsigned MAX_WORDS    = 4;
    localparam int unsigned ADDR_W       = 6;
    localparam int unsigned WORD_IDX_W   = 2;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_STATUS = 2'd1,
        REG_WAKE   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a[3:2])
            2'd0:    s = REG_ENABLE;
            2'd1:    s = REG_STATUS;
            2'd2:    s = REG_WAKE;
            default: s = REG_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [WORD_IDX_W-1:0] decode_word(input logic [ADDR_W-1:0] a);
        return a[5:4];
    endfunction

endpackage

// File: rtl/mlirq_word_bank.sv
module mlirq_word_bank
    import mlirq_pkg::*;
#(
    parameter int unsigned            WORD_IDX = 0,
    parameter logic [WORD_BITS-1:0]   FWD      = '0,
    parameter logic [WORD_BITS-1:0]   USED     = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WORD_BITS-1:0]   src_word,
    input  logic                   wr_en,
    input  logic [WORD_IDX_W-1:0]  wr_word,
    input  reg_sel_e               wr_sel,
    input  logic [WORD_BITS-1:0]   wr_data,
    output logic [WORD_BITS-1:0]   status_q,
    output logic [WORD_BITS-1:0]   enable_q,
    output logic [WORD_BITS-1:0]   wake_en_q
);

    logic hit;
    assign hit = wr_en && (wr_word == WORD_IDX_W'(WORD_IDX));

    // status: one register stage on the raw inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= src_word;
        end
    end

    // writable enable and wake-enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= FWD & USED;
            wake_en_q <= '0;
        end else if (hit) begin
            case (wr_sel)
                REG_ENABLE: enable_q  <= wr_data & USED;
                REG_WAKE:   wake_en_q <= wr_data & USED;
                default:    ;
            endcase
        end
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && wr_sel == REG_ENABLE) |=> $stable(enable_q)) else $error("enable changed without write"); // R10

    AST_UNUSED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((enable_q | wake_en_q) & ~USED) == '0) else $error("unused bit set"); // R8

    AST_STATUS_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_sel == REG_STATUS) |=> (status_q == $past(src_word))) else $error("status took write"); // R7

endmodule

// File: rtl/mlirq_route.sv
module mlirq_route
    import mlirq_pkg::*;
#(
    parameter int unsigned NUM_WORDS   = 2,
    parameter int unsigned NUM_PARENTS = 2,
    parameter logic [NUM_PARENTS*NUM_WORDS*WORD_BITS-1:0] MAP_MASK = '1
) (
    input  logic [NUM_WORDS*WORD_BITS-1:0] status_all,
    input  logic [NUM_WORDS*WORD_BITS-1:0] enable_all,
    input  logic [NUM_WORDS*WORD_BITS-1:0] wake_en_all,
    output logic [NUM_PARENTS-1:0]         parent_irq,
    output logic                           wake_irq
);

    localparam int unsigned SPAN = NUM_WORDS * WORD_BITS;

    logic [SPAN-1:0] pending;
    assign pending = status_all & enable_all;

    // parent-major packing: one contiguous slice per parent
    for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_parent
        localparam logic [SPAN-1:0] SEL = MAP_MASK[p*SPAN +: SPAN];
        assign parent_irq[p] = |(pending & SEL);
    end

    assign wake_irq = |(status_all & wake_en_all);

endmodule

// File: rtl/mlirq_readback.sv
module mlirq_readback
    import mlirq_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [WORD_IDX_W-1:0]          rd_word,
    input  reg_sel_e                       rd_sel,
    input  logic [NUM_WORDS*WORD_BITS-1:0] status_all,
    input  logic [NUM_WORDS*WORD_BITS-1:0] enable_all,
    input  logic [NUM_WORDS*WORD_BITS-1:0] wake_en_all,
    output logic [WORD_BITS-1:0]           rd_data
);

    logic [WORD_BITS-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_word == WORD_IDX_W'(w)) begin
                case (rd_sel)
                    REG_ENABLE: sel_word = enable_all[w*WORD_BITS +: WORD_BITS];
                    REG_STATUS: sel_word = status_all[w*WORD_BITS +: WORD_BITS];
                    REG_WAKE:   sel_word = wake_en_all[w*WORD_BITS +: WORD_BITS];
                    default:    sel_word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel_word;
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)) else $error("read data moved without read"); // R3

endmodule

// File: rtl/mlirq_aggregator.sv
module mlirq_aggregator
    import mlirq_pkg::*;
#(
    parameter int unsigned NUM_WORDS   = 2,
    parameter int unsigned NUM_PARENTS = 2,
    parameter logic [NUM_PARENTS*NUM_WORDS*32-1:0] MAP_MASK =
        {32'h0000_FF00, 32'hFFFF_0000, 32'h0000_00FF, 32'h0000_FFFF},
    parameter logic [NUM_WORDS*32-1:0] FWD_MASK = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_WORDS*32-1:0]   src_i,
    input  logic [5:0]                bus_addr,
    input  logic                      bus_wr,
    input  logic [31:0]               bus_wdata,
    input  logic                      bus_rd,
    output logic [31:0]               bus_rdata,
    output logic [NUM_PARENTS-1:0]    parent_irq,
    output logic                      wake_irq
);

    localparam int unsigned SPAN = NUM_WORDS * WORD_BITS;

    function automatic logic [WORD_BITS-1:0] used_of(input int unsigned w);
        logic [WORD_BITS-1:0] u;
        u = '0;
        for (int unsigned p = 0; p < NUM_PARENTS; p++) begin
            u = u | MAP_MASK[(p*NUM_WORDS + w)*WORD_BITS +: WORD_BITS];
        end
        return u;
    endfunction

    logic [SPAN-1:0]       status_all;
    logic [SPAN-1:0]       enable_all;
    logic [SPAN-1:0]       wake_en_all;
    logic [WORD_IDX_W-1:0] acc_word;
    reg_sel_e              acc_sel;

    assign acc_word = decode_word(bus_addr);
    assign acc_sel  = decode_sel(bus_addr);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        mlirq_word_bank #(
            .WORD_IDX (w),
            .FWD      (FWD_MASK[w*WORD_BITS +: WORD_BITS]),
            .USED     (used_of(w))
        ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_word  (src_i[w*WORD_BITS +: WORD_BITS]),
            .wr_en     (bus_wr),
            .wr_word   (acc_word),
            .wr_sel    (acc_sel),
            .wr_data   (bus_wdata),
            .status_q  (status_all[w*WORD_BITS +: WORD_BITS]),
            .enable_q  (enable_all[w*WORD_BITS +: WORD_BITS]),
            .wake_en_q (wake_en_all[w*WORD_BITS +: WORD_BITS])
        );
    end

    mlirq_route #(
        .NUM_WORDS   (NUM_WORDS),
        .NUM_PARENTS (NUM_PARENTS),
        .MAP_MASK    (MAP_MASK)
    ) i_route (
        .status_all  (status_all),
        .enable_all  (enable_all),
        .wake_en_all (wake_en_all),
        .parent_irq  (parent_irq),
        .wake_irq    (wake_irq)
    );

    mlirq_readback #(
        .NUM_WORDS (NUM_WORDS)
    ) i_readback (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (bus_rd),
        .rd_word     (acc_word),
        .rd_sel      (acc_sel),
        .status_all  (status_all),
        .enable_all  (enable_all),
        .wake_en_all (wake_en_all),
        .rd_data     (bus_rdata)
    );

    AST_PARENT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|parent_irq) |-> (|(status_all & enable_all))) else $error("parent without pending"); // R5

    AST_QUIET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> (parent_irq == '0 && !wake_irq)) else $error("output without source"); // R6

    AST_WAKE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_all == '0) |-> !wake_irq) else $error("wake without status"); // R9

endmodule

// File: tb/test_mlirq_aggregator.sv
module test_mlirq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  parent;
    logic        wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mlirq_aggregator #(
        .NUM_WORDS   (2),
        .NUM_PARENTS (2),
        .FWD_MASK    (64'h0000_0000_0000_0003)
    ) i_mlirq_aggregator (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .bus_addr   (addr),
        .bus_wr     (wr),
        .bus_wdata  (wdata),
        .bus_rd     (rd),
        .bus_rdata  (rdata),
        .parent_irq (parent),
        .wake_irq   (wake)
    );

    // routing: parent0 = w0[15:0] | w1[7:0]; parent1 = w0[31:16] | w1[15:8]
    typedef struct packed {
        logic [31:0] src1;
        logic [31:0] src0;
        logic [31:0] en1;
        logic [31:0] en0;
        logic [1:0]  exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0, 32'h0000_0001, 32'h0,         32'h0000_0001, 2'b01},
        '{32'h0, 32'h0001_0000, 32'h0,         32'hFFFF_FFFF, 2'b10},
        '{32'h0, 32'h0000_0001, 32'h0,         32'h0,         2'b00},
        '{32'h0000_0080, 32'h0, 32'h0000_00FF, 32'h0,         2'b01},
        '{32'h0000_0100, 32'h0, 32'hFFFF_FFFF, 32'h0,         2'b10},
        '{32'h0001_0000, 32'h0, 32'hFFFF_FFFF, 32'h0,         2'b00},
        '{32'h0, 32'h8000_8000, 32'h0,         32'hFFFF_FFFF, 2'b11},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0,         2'b00}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        @(negedge clk);
        // R1 during reset
        check("R1 parent in reset", {30'd0, parent}, 32'd0);
        check("R1 wake in reset", {31'd0, wake}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", rdata, 32'd0);
        bus_read(6'h00, d); check("R1 enable0 reset = fwd", d, 32'h0000_0003);
        bus_read(6'h10, d); check("R1 enable1 reset = 0", d, 32'h0);
        bus_read(6'h08, d); check("R1 wake-enable0 reset", d, 32'h0);

        // table walk: R5, R11, R8
        foreach (VECS[i]) begin
            bus_write(6'h00, VECS[i].en0);
            bus_write(6'h10, VECS[i].en1);
            src = {VECS[i].src1, VECS[i].src0};
            @(negedge clk);
            check($sformatf("R5 R11 vector %0d parents", i), {30'd0, parent}, {30'd0, VECS[i].exp});
            src = '0;
            @(negedge clk);
        end

        // R3: read data holds without a read
        src = 64'h0000_0000_A5A5_0000;
        @(negedge clk);
        bus_read(6'h04, d); check("R4 status0 = raw", d, 32'hA5A5_0000);
        held = d;
        src = '0;
        repeat (3) @(negedge clk);
        check("R3 rdata holds", rdata, held);

        // R2: empty offset and absent word
        bus_read(6'h0C, d); check("R2 offset 0xC reads 0", d, 32'h0);
        bus_read(6'h24, d); check("R2 absent word reads 0", d, 32'h0);
        src = 64'h0000_1234_0000_0000;
        @(negedge clk);
        bus_read(6'h14, d); check("R2 R4 status1 address", d, 32'h0000_1234);

        // R7: status write ignored
        src = 64'h0000_0000_0000_00F0;
        @(negedge clk);
        bus_write(6'h04, 32'hFFFF_FFFF);
        bus_read(6'h04, d); check("R7 status unchanged by write", d, 32'h0000_00F0);
        bus_write(6'h00, 32'h0);
        bus_write(6'h04, 32'h0000_00F0);
        check("R7 no parent from status write", {30'd0, parent}, 32'd0);

        // R8: unused bits cannot be enabled
        bus_write(6'h10, 32'hFFFF_FFFF);
        bus_read(6'h10, d); check("R8 enable1 masks unused", d, 32'h0000_FFFF);
        bus_write(6'h18, 32'hFFFF_FFFF);
        bus_read(6'h18, d); check("R8 wake-enable1 masks unused", d, 32'h0000_FFFF);
        src = 64'h0001_0000_0000_0000;
        @(negedge clk);
        check("R8 unused source no wake", {31'd0, wake}, 32'd0);
        bus_write(6'h18, 32'h0);
        bus_write(6'h10, 32'h0);

        // R9: wake independent of enable
        bus_write(6'h08, 32'h0000_0001);
        src = 64'h0000_0000_0000_0001;
        @(negedge clk);
        check("R9 wake set", {31'd0, wake}, 32'd1);
        check("R9 parents stay low", {30'd0, parent}, 32'd0);
        bus_write(6'h08, 32'h0);
        check("R9 wake cleared by wake-enable", {31'd0, wake}, 32'd0);

        // R10: enable write takes effect on accepting edge
        bus_write(6'h00, 32'h0000_0001);
        check("R10 parent after enable write", {30'd0, parent}, 32'd1);

        // R6: level hold, one-clock lag on release
        repeat (3) @(negedge clk);
        check("R6 parent holds without ack", {30'd0, parent}, 32'd1);
        src = '0;
        #1;
        check("R6 parent before edge", {30'd0, parent}, 32'd1);
        @(negedge clk);
        check("R6 parent drops after one clock", {30'd0, parent}, 32'd0);
        src = 64'h0000_0000_0000_0001;
        #1;
        check("R4 one-clock lag on rise", {30'd0, parent}, 32'd0);
        @(negedge clk);
        check("R4 parent after lag", {30'd0, parent}, 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule